// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Word-Granular Dirty Tracking

This block is a direct-mapped data cache placed between a processor load/store port and a slower next-level memory. Stores that hit change only the cache copy and mark the word they touched as modified. Stores that miss first bring the entire line in from memory and then apply the store to it. Memory receives data in two cases only: when a line holding modified words is displaced, and during a flush. In both cases only the modified words are sent, one word per memory transaction.

The processor holds a request with its address and data stable. The cache returns the result combinationally on a hit. On a miss it holds `cpu_stall` high until the access can finish. The memory side moves one word per request. A request stays asserted, with address and data held steady, until `mem_ack` returns, so the memory may answer after any number of cycles.

Two maintenance inputs support I/O. An invalidate drops the line that holds a given address, discarding its modified words, because the memory region is about to be overwritten by an incoming transfer. A flush walks every line and writes back all modified words, so that an outgoing transfer reads current data. The lines stay valid after a flush.

Top module: `wbc_cache`

## Requirements
- R1: After reset no line is valid and no word is dirty. The first access to any address is a miss, and `mem_req` stays low while nothing is requested.
- R2: A read that hits returns the stored word on `cpu_rdata` in the same cycle with `cpu_stall` low, and it causes no memory transaction.
- R3: A write that hits completes without stalling and causes no memory transaction. It updates the cached word, and that word is marked dirty.
- R4: A read miss fetches the whole line with one read transaction per word. The reads go in ascending word order, at byte addresses {tag, index, word, 2'b00}, and the requested word is returned once the line is filled.
- R5: A write miss first fetches the whole line, then merges the store. The stored word reads back with the new value, and the other words read back with the memory contents.
- R6: When a valid line is displaced, only its dirty words are written to memory, at the old tag's addresses and in ascending word order, before the refill reads begin. A clean line is displaced with no write.
- R7: An invalidate (`inv_req` high for one cycle while idle) clears the line that holds `inv_addr` if the tag matches. Its dirty words are discarded without a write, and the next access to that line misses. An invalidate whose tag does not match has no effect.
- R8: A flush (`flush_req` high for one cycle while idle) writes back every dirty word, lines in ascending index order and words in ascending order, and `cpu_stall` stays high until it is done. The lines remain valid and clean, so a second flush writes nothing.
- R9: `cpu_stall` is high for every cycle in which the controller is busy or a pending access misses. An unacknowledged memory request keeps its address, direction and write data unchanged in the next cycle.
- R10: Each dirty word is written back exactly once. After the write, it is no longer dirty.
- R11: Address fields: bits [3:2] select the word, bits [7:4] select the line, and bits [31:8] form the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when stall is low |
| cpu_stall | output | 1 | Access not yet complete or controller busy |
| inv_req | input | 1 | Invalidate the line holding inv_addr |
| inv_addr | input | 32 | Address to invalidate |
| flush_req | input | 1 | Start writing back all dirty words |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write one word, 0 = read one word |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transaction complete |

## Verification
The bench uses the default geometry: sixteen lines of four 32-bit words. Because the index is small, conflicting addresses that share a line are easy to construct. This makes it easy to set up evictions with one, two or no dirty words. The 16-line flush walk finishes in a few dozen cycles. The memory model in the bench rotates its response latency from zero to three cycles, so held requests and back-to-back transactions both occur during fills, evictions and flushes.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int LINES  = 16;
    parameter int WORDS  = 4;

    localparam int BYTE_BITS = $clog2(DATA_W / 8);
    localparam int WORD_BITS = $clog2(WORDS);
    localparam int IDX_BITS  = $clog2(LINES);
    localparam int TAG_W     = ADDR_W - IDX_BITS - WORD_BITS - BYTE_BITS;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL,
        ST_FLUSH
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e                           fsm;
        logic [ADDR_W-1:0]                    addr;
        logic [WORD_BITS-1:0]                 cnt;
        logic [IDX_BITS-1:0]                  fl_line;
        logic [LINES-1:0]                     valid;
        logic [LINES-1:0][WORDS-1:0]          dirty;
        logic [LINES-1:0][TAG_W-1:0]          tag;
    } ctl_regs_t;

    function automatic logic [IDX_BITS-1:0] f_idx(input logic [ADDR_W-1:0] a);
        return a[BYTE_BITS+WORD_BITS +: IDX_BITS];
    endfunction

    function automatic logic [WORD_BITS-1:0] f_word(input logic [ADDR_W-1:0] a);
        return a[BYTE_BITS +: WORD_BITS];
    endfunction

    function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic logic [ADDR_W-1:0] f_mk(input logic [TAG_W-1:0] t,
                                               input logic [IDX_BITS-1:0] i,
                                               input logic [WORD_BITS-1:0] w);
        return {t, i, w, {BYTE_BITS{1'b0}}};
    endfunction
endpackage

// File: rtl/wbc_dirty_pick.sv
module wbc_dirty_pick #(
    parameter int WORDS     = 4,
    parameter int WORD_BITS = $clog2(WORDS)
) (
    input  logic [WORDS-1:0]     dirty,
    output logic                 any,
    output logic [WORD_BITS-1:0] word
);
    always_comb begin
        word = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (dirty[i]) word = WORD_BITS'(i);
        end
        any = |dirty;
    end
endmodule

// File: rtl/wbc_data_ram.sv
module wbc_data_ram #(
    parameter int LINES     = 16,
    parameter int WORDS     = 4,
    parameter int DATA_W    = 32,
    parameter int IDX_BITS  = $clog2(LINES),
    parameter int WORD_BITS = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [IDX_BITS-1:0]  w_line,
    input  logic [WORD_BITS-1:0] w_word,
    input  logic [DATA_W-1:0]    w_data,
    input  logic [IDX_BITS-1:0]  r_line,
    input  logic [WORD_BITS-1:0] r_word,
    output logic [DATA_W-1:0]    r_data
);
    localparam int DEPTH = LINES * WORDS;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[{w_line, w_word}] <= w_data;
    end

    assign r_data = store_q[{r_line, r_word}];
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    input  logic              inv_req,
    input  logic [ADDR_W-1:0] inv_addr,
    input  logic              flush_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    ctl_regs_t st_q, st_d;

    logic [IDX_BITS-1:0]  cpu_idx, miss_idx, inv_idx, wb_line, r_line, w_line;
    logic [WORD_BITS-1:0] cpu_word, pick_word, r_word, w_word;
    logic                 hit, inv_hit, pick_any, ram_we;
    logic [DATA_W-1:0]    ram_rdata, ram_wdata;

    assign cpu_idx  = f_idx(cpu_addr);
    assign cpu_word = f_word(cpu_addr);
    assign miss_idx = f_idx(st_q.addr);
    assign inv_idx  = f_idx(inv_addr);
    assign hit      = st_q.valid[cpu_idx] && (st_q.tag[cpu_idx] == f_tag(cpu_addr));
    assign inv_hit  = st_q.valid[inv_idx] && (st_q.tag[inv_idx] == f_tag(inv_addr));
    assign wb_line  = (st_q.fsm == ST_FLUSH) ? st_q.fl_line : miss_idx;

    wbc_dirty_pick #(.WORDS(WORDS)) u_pick (
        .dirty (st_q.dirty[wb_line]),
        .any   (pick_any),
        .word  (pick_word)
    );

    wbc_data_ram #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
        .clk    (clk),
        .we     (ram_we),
        .w_line (w_line),
        .w_word (w_word),
        .w_data (ram_wdata),
        .r_line (r_line),
        .r_word (r_word),
        .r_data (ram_rdata)
    );

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        w_line    = cpu_idx;
        w_word    = cpu_word;
        ram_wdata = cpu_wdata;
        r_line    = cpu_idx;
        r_word    = cpu_word;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = ram_rdata;
        cpu_stall = 1'b1;

        unique case (st_q.fsm)
            ST_IDLE: begin
                if (inv_req) begin
                    if (inv_hit) begin
                        st_d.valid[inv_idx] = 1'b0;
                        st_d.dirty[inv_idx] = '0;
                    end
                end else if (flush_req) begin
                    st_d.fsm     = ST_FLUSH;
                    st_d.fl_line = '0;
                end else if (cpu_req && !hit) begin
                    st_d.addr = cpu_addr;
                    st_d.cnt  = '0;
                    st_d.fsm  = (st_q.valid[cpu_idx] && |st_q.dirty[cpu_idx]) ? ST_EVICT : ST_FILL;
                end else begin
                    cpu_stall = 1'b0;
                    if (cpu_req && cpu_we) begin
                        ram_we = 1'b1;
                        st_d.dirty[cpu_idx][cpu_word] = 1'b1;
                    end
                end
            end
            ST_EVICT, ST_FLUSH: begin
                r_line = wb_line;
                r_word = pick_word;
                if (pick_any) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = f_mk(st_q.tag[wb_line], wb_line, pick_word);
                    if (mem_ack) st_d.dirty[wb_line][pick_word] = 1'b0;
                end else if (st_q.fsm == ST_EVICT) begin
                    st_d.fsm = ST_FILL;
                end else if (st_q.fl_line == IDX_BITS'(LINES - 1)) begin
                    st_d.fsm = ST_IDLE;
                end else begin
                    st_d.fl_line = st_q.fl_line + 1'b1;
                end
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_addr  = f_mk(f_tag(st_q.addr), miss_idx, st_q.cnt);
                w_line    = miss_idx;
                w_word    = st_q.cnt;
                ram_wdata = mem_rdata;
                if (mem_ack) begin
                    ram_we   = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                    if (st_q.cnt == WORD_BITS'(WORDS - 1)) begin
                        st_d.tag[miss_idx]   = f_tag(st_q.addr);
                        st_d.valid[miss_idx] = 1'b1;
                        st_d.dirty[miss_idx] = '0;
                        st_d.fsm             = ST_IDLE;
                    end
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    assign cpu_rdata = ram_rdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a waiting memory request holds its address, direction and data
    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R9: a busy controller always stalls the processor
    assert_busy_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm != ST_IDLE) |-> cpu_stall);

    // R6, R10: every memory write targets a word still marked dirty
    assert_wb_dirty_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> st_q.dirty[f_idx(mem_addr)][f_word(mem_addr)]);

    // R4: the last fill beat leaves a valid, clean line
    assert_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == ST_FILL && mem_ack && st_q.cnt == WORD_BITS'(WORDS - 1))
        |=> (st_q.valid[f_idx(st_q.addr)] && st_q.dirty[f_idx(st_q.addr)] == '0));

    // R3: a completed store leaves its word dirty
    assert_store_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && !cpu_stall)
        |=> st_q.dirty[$past(f_idx(cpu_addr))][$past(f_word(cpu_addr))]);

    // R7: after an invalidate, the named address no longer hits
    assert_inv_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == ST_IDLE && inv_req)
        |=> !(st_q.valid[$past(f_idx(inv_addr))] && st_q.tag[$past(f_idx(inv_addr))] == $past(f_tag(inv_addr))));
endmodule

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic        cpu_stall;
    logic        inv_req = 1'b0, flush_req = 1'b0;
    logic [31:0] inv_addr = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, fails = 0;
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] gold [logic [31:0]];
    logic [31:0] wlog [64];
    logic [31:0] rlog [64];
    int nw = 0, nr = 0, lat = 0;

    always #10 clk = ~clk;

    wbc_cache u_wbc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_stall(cpu_stall), .inv_req(inv_req), .inv_addr(inv_addr),
        .flush_req(flush_req), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    function automatic logic [31:0] init_val(input logic [31:0] a);
        return (a * 32'd3) + 32'h1000_0007;
    endfunction

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : init_val(a);
    endfunction

    function automatic logic [31:0] exp_val(input logic [31:0] a);
        return gold.exists(a) ? gold[a] : mem_val(a);
    endfunction

    // memory responder, latency rotates 0..3 cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                repeat (lat) @(negedge clk);
                if (mem_we) begin
                    bmem[mem_addr] = mem_wdata;
                    if (nw < 64) wlog[nw] = mem_addr;
                    nw++;
                end else begin
                    mem_rdata = mem_val(mem_addr);
                    if (nr < 64) rlog[nr] = mem_addr;
                    nr++;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                lat = (lat + 1) % 4;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0;
        nr = 0;
    endtask

    task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int stalls);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        stalls = 0;
        #1;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = cpu_rdata;
        if (we) gold[a] = d;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic check_fill(input string req, input logic [31:0] a);
        logic [31:0] base;
        base = {a[31:4], 4'h0};
        check(nr == 4, req, 32'(nr), 32'd4);
        for (int i = 0; i < 4; i++)
            check(rlog[i] == base + 32'(4 * i), req, rlog[i], base + 32'(4 * i));
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        #1;
        while (cpu_stall) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic do_inv(input logic [31:0] a);
        @(negedge clk);
        inv_req = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; int st;
        check(!cpu_stall, "R1 stall idle", 32'(cpu_stall), 0);
        check(!mem_req, "R1 mem_req idle", 32'(mem_req), 0);
        clear_log();
        access(0, 32'h0000_1230, 0, rd, st);
        check(st >= 4, "R1/R9 first access stalls", 32'(st), 4);
        check_fill("R4 R11 fill order", 32'h0000_1230);
        check(nw == 0, "R1 no writeback", 32'(nw), 0);
        check(rd == exp_val(32'h0000_1230), "R4 read miss data", rd, exp_val(32'h0000_1230));
    endtask

    task automatic t_hits();
        logic [31:0] rd; int st;
        clear_log();
        access(0, 32'h0000_123C, 0, rd, st);
        check(st == 0 && nr == 0 && nw == 0, "R2 hit no stall/mem", 32'(st + nr + nw), 0);
        check(rd == exp_val(32'h0000_123C), "R2 hit data", rd, exp_val(32'h0000_123C));
        access(1, 32'h0000_1238, 32'hCAFE_0001, rd, st);
        check(st == 0 && nr == 0 && nw == 0, "R3 write hit no mem", 32'(st + nr + nw), 0);
        access(0, 32'h0000_1238, 0, rd, st);
        check(rd == 32'hCAFE_0001, "R3 write hit readback", rd, 32'hCAFE_0001);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; int st;
        clear_log();
        access(1, 32'h0000_2054, 32'hBEEF_0002, rd, st);
        check_fill("R5 allocate fill", 32'h0000_2054);
        access(0, 32'h0000_2054, 0, rd, st);
        check(rd == 32'hBEEF_0002, "R5 merged store", rd, 32'hBEEF_0002);
        access(0, 32'h0000_2050, 0, rd, st);
        check(rd == init_val(32'h0000_2050), "R5 other word from memory", rd, init_val(32'h0000_2050));
    endtask

    task automatic t_evict();
        logic [31:0] rd; int st;
        clear_log();
        access(0, 32'h0000_4530, 0, rd, st);
        check(nw == 1, "R6 one dirty word written", 32'(nw), 1);
        check(wlog[0] == 32'h0000_1238, "R6 writeback address", wlog[0], 32'h0000_1238);
        check(mem_val(32'h0000_1238) == 32'hCAFE_0001, "R6 writeback data", mem_val(32'h0000_1238), 32'hCAFE_0001);
        check_fill("R6 refill after writeback", 32'h0000_4530);
        clear_log();
        access(0, 32'h0000_7734, 0, rd, st);
        check(nw == 0, "R6 clean line no write", 32'(nw), 0);
        check(rd == exp_val(32'h0000_7734), "R6 clean replace data", rd, exp_val(32'h0000_7734));
        access(1, 32'h0000_773C, 32'h3333_0003, rd, st);
        access(1, 32'h0000_7734, 32'h1111_0001, rd, st);
        clear_log();
        access(0, 32'h0000_9930, 0, rd, st);
        check(nw == 2, "R10 two dirty words", 32'(nw), 2);
        check(wlog[0] == 32'h0000_7734 && wlog[1] == 32'h0000_773C, "R6 word order", wlog[0], 32'h0000_7734);
        clear_log();
        access(0, 32'h0000_7734, 0, rd, st);
        check(nw == 0, "R10 no second writeback", 32'(nw), 0);
        check(rd == 32'h1111_0001, "R10 memory holds written word", rd, 32'h1111_0001);
    endtask

    task automatic t_inv();
        logic [31:0] rd; int st;
        access(0, 32'h0000_3360, 0, rd, st);
        access(1, 32'h0000_3364, 32'hDEAD_0004, rd, st);
        do_inv(32'h0000_3368);
        gold.delete(32'h0000_3364);
        clear_log();
        access(0, 32'h0000_3364, 0, rd, st);
        check(nw == 0, "R7 dirty data dropped", 32'(nw), 0);
        check_fill("R7 miss after invalidate", 32'h0000_3364);
        check(rd == init_val(32'h0000_3364), "R7 memory value", rd, init_val(32'h0000_3364));
        do_inv(32'h0000_5560);
        clear_log();
        access(0, 32'h0000_3360, 0, rd, st);
        check(nr == 0 && nw == 0 && st == 0, "R7 tag mismatch no effect", 32'(nr + nw + st), 0);
    endtask

    task automatic t_flush();
        logic [31:0] rd; int st;
        access(1, 32'h0000_0010, 32'hF00D_0005, rd, st);
        access(1, 32'h0000_2058, 32'hF00D_0006, rd, st);
        access(1, 32'h0000_205C, 32'hF00D_0007, rd, st);
        clear_log();
        do_flush();
        check(nw == 4, "R8 flush write count", 32'(nw), 4);
        check(wlog[0] == 32'h0000_0010, "R8 flush order 0", wlog[0], 32'h0000_0010);
        check(wlog[1] == 32'h0000_2054, "R8 flush order 1", wlog[1], 32'h0000_2054);
        check(wlog[2] == 32'h0000_2058, "R8 flush order 2", wlog[2], 32'h0000_2058);
        check(wlog[3] == 32'h0000_205C, "R8 flush order 3", wlog[3], 32'h0000_205C);
        check(mem_val(32'h0000_205C) == 32'hF00D_0007, "R8 flush data", mem_val(32'h0000_205C), 32'hF00D_0007);
        clear_log();
        access(0, 32'h0000_2054, 0, rd, st);
        check(st == 0 && nr == 0, "R8 lines stay valid", 32'(st + nr), 0);
        check(rd == 32'hBEEF_0002, "R8 data kept", rd, 32'hBEEF_0002);
        clear_log();
        do_flush();
        check(nw == 0, "R8 second flush empty", 32'(nw), 0);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_hits();
        t_write_miss();
        t_evict();
        t_inv();
        t_flush();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule